// File: doc/BRIEF.md
# Cache and Translation Control Register Bank

This block holds the configuration registers that a processor core uses to steer its caches and its address-translation unit. Software reaches the registers over a plain 32-bit register bus: an address, a write strobe with write data, and a read strobe whose data comes back one cycle later. The bank answers in one 256-byte window. That window can be reached at a primary base and, when enabled, at a second alias base.

Every write passes through a mask that belongs to its register. A few bits are commands rather than state: writing a one to them fires a request and the bit is never stored. The bank also watches two fields for changes. When the address-space identifier or the translation-enable bit changes value, the bank raises a request toward the lookup hardware. All requests leave the block as registered pulses one clock wide. The caches, the TLB arrays and the table-walk logic that act on those pulses sit outside this block.

Two identification words are read-only constants. A synchronous manual-reset input brings a subset of the registers back to their defined values and leaves the others unchanged.

Top module: `ccreg_bank`

## Requirements
- R1: An address hits when bits 31:8 equal 0xFF0000 or, with the alias enabled (the default), 0x1F0000. Bits 7:2 select the word and bits 1:0 are ignored. Read data is registered: it appears the cycle after `bus_re_i`, shows the value from before any write in that same cycle, and is zero when no read was made, when the address is outside the window, or when the word is unmapped (0x2C, 0x40). Writes to unmapped or outside addresses change nothing.
- R2: A write to the entry-high word (0x00) stores data AND 0xFFFFFCFF. If bits 7:0 of the write differ from the stored bits 7:0, `lookup_flush_o` pulses.
- R3: A write to the translation-control word (0x10) stores data AND 0xFCFCFF01. If data bit 2 is set, `tlb_flush_o` pulses, and bit 2 always reads back as 0.
- R4: A translation-control write whose bit 0 differs from the stored bit 0 pulses `xlat_mode_o`.
- R5: A write to the cache-control word (0x1C) stores data AND 0x81A7. Data bit 11 pulses `icache_inv_o` and data bit 3 pulses `ocache_inv_o`. Both bits read back as 0.
- R6: The queue-map words at 0x38 and 0x3C each keep only bits 4:2 (mask 0x1C). A write to either one pulses `qremap_o`.
- R7: Word 0x30 always reads 0x040205C1 and word 0x44 always reads 0. Writes to these two words are ignored.
- R8: After `rst_ni` is low, every register reads 0. While `man_rst_i` is high, translation control and cache control are cleared, the exception-code word (0x24) takes 0x00000020, all other registers hold their values, and no write is accepted.
- R9: The break-identifier words at 0x14 and 0x18 keep bits 7:0 and read back zero-extended.
- R10: The words at 0x04, 0x08, 0x0C, 0x20, 0x24, 0x28 and 0x34 are plain 32-bit read/write registers with no side effects.
- R11: Each pulse output is registered. It is high exactly in the cycle after the accepted write that causes it. A write that causes no pulse leaves all pulse outputs low in that following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| man_rst_i | input | 1 | Synchronous manual reset, active high |
| bus_addr_i | input | 32 | Register bus byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| tlb_flush_o | output | 1 | Full TLB flush request pulse |
| lookup_flush_o | output | 1 | Address-lookup flush pulse, sent when the identifier changes |
| icache_inv_o | output | 1 | Instruction-cache invalidate pulse |
| ocache_inv_o | output | 1 | Operand-cache invalidate pulse |
| xlat_mode_o | output | 1 | Translation enable changed pulse |
| qremap_o | output | 1 | Queue-map update pulse |

## Verification
The hardest situations to reach are the ones where a pulse depends on stored state and not only on the write data. A lookup flush and a translation-mode change fire only when the new field differs from the value already held. A random stream therefore has to run long enough for both matching and differing writes to occur. The bench keeps its own shadow of every register, so it can predict each pulse from the prior contents. Directed steps then cover the cases random traffic rarely hits: an identical rewrite of the identifier, toggling the enable bit back and forth, and a manual reset that clears some registers while others are held.

// File: rtl/ccreg_pkg.sv
package ccreg_pkg;

   localparam int unsigned WORD_W = 6;
   localparam int unsigned DATA_W = 32;

   // word indices (byte offset / 4)
   localparam logic [WORD_W-1:0] W_ENTRY_HI   = 6'd0;
   localparam logic [WORD_W-1:0] W_ENTRY_LO   = 6'd1;
   localparam logic [WORD_W-1:0] W_TBL_BASE   = 6'd2;
   localparam logic [WORD_W-1:0] W_FAULT_ADDR = 6'd3;
   localparam logic [WORD_W-1:0] W_XLAT_CTRL  = 6'd4;
   localparam logic [WORD_W-1:0] W_BRK_A      = 6'd5;
   localparam logic [WORD_W-1:0] W_BRK_B      = 6'd6;
   localparam logic [WORD_W-1:0] W_CACHE_CTRL = 6'd7;
   localparam logic [WORD_W-1:0] W_TRAP_CODE  = 6'd8;
   localparam logic [WORD_W-1:0] W_EXC_CODE   = 6'd9;
   localparam logic [WORD_W-1:0] W_INT_CODE   = 6'd10;
   localparam logic [WORD_W-1:0] W_ID         = 6'd12;
   localparam logic [WORD_W-1:0] W_ENTRY_ATTR = 6'd13;
   localparam logic [WORD_W-1:0] W_QMAP0      = 6'd14;
   localparam logic [WORD_W-1:0] W_QMAP1      = 6'd15;
   localparam logic [WORD_W-1:0] W_PROD       = 6'd17;

   // store masks
   localparam logic [DATA_W-1:0] M_ENTRY_HI = 32'hFFFF_FCFF;
   localparam logic [DATA_W-1:0] M_XLAT     = 32'hFCFC_FF05;
   localparam logic [DATA_W-1:0] M_CACHE    = 32'h0000_89AF;
   localparam logic [DATA_W-1:0] M_QMAP     = 32'h0000_001C;

   // bit positions with side effects
   localparam int unsigned XC_EN_BIT    = 0;
   localparam int unsigned XC_FLUSH_BIT = 2;
   localparam int unsigned CC_OINV_BIT  = 3;
   localparam int unsigned CC_IINV_BIT  = 11;

   typedef struct packed {
      logic tlb_flush;
      logic lookup_flush;
      logic icache_inv;
      logic ocache_inv;
      logic xlat_mode;
      logic qremap;
   } pulse_t;

endpackage

// File: rtl/ccreg_decode.sv
module ccreg_decode
   import ccreg_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 32,
   parameter logic [ADDR_W-1:0]    PAGE_BASE  = 32'hFF00_0000,
   parameter logic [ADDR_W-1:0]    ALIAS_BASE = 32'h1F00_0000,
   parameter bit                   ALIAS_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic              wr_ok_o,
   output logic [WORD_W-1:0] word_o
);
   localparam int unsigned PAGE_BITS = WORD_W + 2;
   localparam int unsigned TAG_W     = ADDR_W - PAGE_BITS;

   logic [TAG_W-1:0] tag;
   logic             in_page;
   logic             known;
   logic             read_only;

   assign tag    = addr_i[ADDR_W-1:PAGE_BITS];
   assign word_o = addr_i[PAGE_BITS-1:2];

   generate
      if (ALIAS_EN) begin : g_alias
         assign in_page = (tag == PAGE_BASE[ADDR_W-1:PAGE_BITS]) ||
                          (tag == ALIAS_BASE[ADDR_W-1:PAGE_BITS]);
      end else begin : g_single
         assign in_page = (tag == PAGE_BASE[ADDR_W-1:PAGE_BITS]);
      end
   endgenerate

   always_comb begin
      known     = 1'b0;
      read_only = 1'b0;
      case (word_o)
         W_ENTRY_HI, W_ENTRY_LO, W_TBL_BASE, W_FAULT_ADDR, W_XLAT_CTRL,
         W_BRK_A, W_BRK_B, W_CACHE_CTRL, W_TRAP_CODE, W_EXC_CODE,
         W_INT_CODE, W_ENTRY_ATTR, W_QMAP0, W_QMAP1: known = 1'b1;
         W_ID, W_PROD: begin
            known     = 1'b1;
            read_only = 1'b1;
         end
         default: known = 1'b0;
      endcase
   end

   assign hit_o   = in_page && known;
   assign wr_ok_o = hit_o && !read_only;

endmodule

// File: rtl/ccreg_file.sv
module ccreg_file
   import ccreg_pkg::*;
#(
   parameter int unsigned        ASID_W      = 8,
   parameter int unsigned        BRK_W       = 8,
   parameter int unsigned        QMAP_N      = 2,
   parameter logic [DATA_W-1:0]  VERSION_ID  = 32'h0402_05C1,
   parameter logic [DATA_W-1:0]  PROD_ID     = 32'h0000_0000,
   parameter logic [DATA_W-1:0]  MANUAL_EXC  = 32'h0000_0020
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              man_rst_i,
   input  logic              we_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [ASID_W-1:0] asid_o,
   output logic              xlat_en_o
);
   localparam int unsigned N_PLAIN = 6;
   localparam int unsigned N_BRK   = 2;
   localparam logic [WORD_W-1:0] PLAIN_W [N_PLAIN] =
      '{W_ENTRY_LO, W_TBL_BASE, W_FAULT_ADDR, W_TRAP_CODE, W_INT_CODE, W_ENTRY_ATTR};
   localparam logic [WORD_W-1:0] BRK_WD  [N_BRK]  = '{W_BRK_A, W_BRK_B};
   localparam logic [WORD_W-1:0] QMAP_WD [2]      = '{W_QMAP0, W_QMAP1};
   localparam logic [DATA_W-1:0] XC_STORE = M_XLAT  & ~(DATA_W'(1) << XC_FLUSH_BIT);
   localparam logic [DATA_W-1:0] CC_STORE = M_CACHE & ~((DATA_W'(1) << CC_IINV_BIT) |
                                                        (DATA_W'(1) << CC_OINV_BIT));

   generate
      if (BRK_W > DATA_W || BRK_W == 0) begin : g_bad_brk
         $error("BRK_W must be 1..DATA_W");
      end
      if (QMAP_N != 2) begin : g_bad_qmap
         $error("QMAP_N must be 2");
      end
   endgenerate

   logic [DATA_W-1:0] entry_hi_q;
   logic [DATA_W-1:0] xlat_q;
   logic [DATA_W-1:0] cache_q;
   logic [DATA_W-1:0] exc_q;
   logic [DATA_W-1:0] plain_q [N_PLAIN];
   logic [BRK_W-1:0]  brk_q   [N_BRK];
   logic [DATA_W-1:0] qmap_q  [QMAP_N];

   // registers held across a manual reset
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         entry_hi_q <= '0;
      else if (we_i && word_i == W_ENTRY_HI)
         entry_hi_q <= wdata_i & M_ENTRY_HI;
   end

   generate
      for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               plain_q[g] <= '0;
            else if (we_i && word_i == PLAIN_W[g])
               plain_q[g] <= wdata_i;
         end
      end
      for (genvar g = 0; g < N_BRK; g++) begin : g_brk
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               brk_q[g] <= '0;
            else if (we_i && word_i == BRK_WD[g])
               brk_q[g] <= wdata_i[BRK_W-1:0];
         end
      end
      for (genvar g = 0; g < QMAP_N; g++) begin : g_qmap
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               qmap_q[g] <= '0;
            else if (we_i && word_i == QMAP_WD[g])
               qmap_q[g] <= wdata_i & M_QMAP;
         end
      end
   endgenerate

   // registers with a defined manual-reset value
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         xlat_q  <= '0;
         cache_q <= '0;
         exc_q   <= '0;
      end else if (man_rst_i) begin
         xlat_q  <= '0;
         cache_q <= '0;
         exc_q   <= MANUAL_EXC;
      end else if (we_i) begin
         if (word_i == W_XLAT_CTRL)  xlat_q  <= wdata_i & XC_STORE;
         if (word_i == W_CACHE_CTRL) cache_q <= wdata_i & CC_STORE;
         if (word_i == W_EXC_CODE)   exc_q   <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      case (word_i)
         W_ENTRY_HI:   rdata_o = entry_hi_q;
         W_XLAT_CTRL:  rdata_o = xlat_q;
         W_CACHE_CTRL: rdata_o = cache_q;
         W_EXC_CODE:   rdata_o = exc_q;
         W_ID:         rdata_o = VERSION_ID;
         W_PROD:       rdata_o = PROD_ID;
         default:      rdata_o = '0;
      endcase
      for (int i = 0; i < N_PLAIN; i++)
         if (word_i == PLAIN_W[i]) rdata_o = plain_q[i];
      for (int i = 0; i < N_BRK; i++)
         if (word_i == BRK_WD[i]) rdata_o = DATA_W'(brk_q[i]);
      for (int i = 0; i < QMAP_N; i++)
         if (word_i == QMAP_WD[i]) rdata_o = qmap_q[i];
   end

   assign asid_o    = entry_hi_q[ASID_W-1:0];
   assign xlat_en_o = xlat_q[XC_EN_BIT];

   // R8: manual reset lands on defined values and leaves held registers alone
   a_r8_manual_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
      man_rst_i |=> (exc_q == MANUAL_EXC) && (xlat_q == '0) && (cache_q == '0));
   a_r8_manual_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      man_rst_i |=> entry_hi_q == $past(entry_hi_q));
   // R3: the flush command bit never lingers in state
   a_r3_flush_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && word_i == W_XLAT_CTRL) |=> !xlat_q[XC_FLUSH_BIT]);

endmodule

// File: rtl/ccreg_cmd.sv
module ccreg_cmd
   import ccreg_pkg::*;
#(
   parameter int unsigned ASID_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              man_rst_i,
   input  logic              we_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ASID_W-1:0] asid_i,
   input  logic              xlat_en_i,
   output pulse_t            pulse_o
);
   pulse_t nxt;
   pulse_t pulse_q;

   always_comb begin
      nxt = '0;
      if (we_i) begin
         case (word_i)
            W_ENTRY_HI:
               nxt.lookup_flush = (wdata_i[ASID_W-1:0] != asid_i);
            W_XLAT_CTRL: begin
               nxt.tlb_flush = wdata_i[XC_FLUSH_BIT];
               nxt.xlat_mode = (wdata_i[XC_EN_BIT] != xlat_en_i);
            end
            W_CACHE_CTRL: begin
               nxt.icache_inv = wdata_i[CC_IINV_BIT];
               nxt.ocache_inv = wdata_i[CC_OINV_BIT];
            end
            W_QMAP0, W_QMAP1:
               nxt.qremap = 1'b1;
            default: nxt = '0;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pulse_q <= '0;
      else if (man_rst_i) pulse_q <= '0;
      else                pulse_q <= nxt;
   end

   assign pulse_o = pulse_q;

   // R3: a flush pulse traces back to a command write
   a_r3_flush_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q.tlb_flush |-> $past(we_i && word_i == W_XLAT_CTRL && wdata_i[XC_FLUSH_BIT]));
   // R2: lookup flush only after an entry-high write
   a_r2_lookup_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q.lookup_flush |-> $past(we_i && word_i == W_ENTRY_HI));
   // R4: mode pulse coincides with a changed enable in the register file
   a_r4_mode_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_q.xlat_mode |-> (xlat_en_i != $past(xlat_en_i)));
   // R5: invalidate pulses trace back to cache-control writes
   a_r5_inv_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pulse_q.icache_inv || pulse_q.ocache_inv) |-> $past(we_i && word_i == W_CACHE_CTRL));
   // R11: manual reset silences all pulses
   a_r11_quiet_after_manual: assert property (@(posedge clk_i) disable iff (!rst_ni)
      man_rst_i |=> pulse_q == '0);

endmodule

// File: rtl/ccreg_bank.sv
module ccreg_bank
   import ccreg_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       ASID_W     = 8,
   parameter int unsigned       BRK_W      = 8,
   parameter bit                ALIAS_EN   = 1'b1,
   parameter logic [31:0]       PAGE_BASE  = 32'hFF00_0000,
   parameter logic [31:0]       ALIAS_BASE = 32'h1F00_0000,
   parameter logic [31:0]       VERSION_ID = 32'h0402_05C1,
   parameter logic [31:0]       PROD_ID    = 32'h0000_0000,
   parameter logic [31:0]       MANUAL_EXC = 32'h0000_0020
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        man_rst_i,
   input  logic [31:0] bus_addr_i,
   input  logic        bus_we_i,
   input  logic [31:0] bus_wdata_i,
   input  logic        bus_re_i,
   output logic [31:0] bus_rdata_o,
   output logic        tlb_flush_o,
   output logic        lookup_flush_o,
   output logic        icache_inv_o,
   output logic        ocache_inv_o,
   output logic        xlat_mode_o,
   output logic        qremap_o
);
   generate
      if (ADDR_W != 32) begin : g_bad_addr
         $error("ADDR_W must be 32");
      end
      if (ASID_W == 0 || ASID_W > 8) begin : g_bad_asid
         $error("ASID_W must be 1..8, the field sits below the masked bits 9:8");
      end
   endgenerate

   logic              hit, wr_ok, we_acc;
   logic [WORD_W-1:0] word;
   logic [DATA_W-1:0] rd_comb, rdata_q;
   logic [ASID_W-1:0] asid;
   logic              xlat_en;
   pulse_t            pulse;

   ccreg_decode #(
      .ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE), .ALIAS_BASE(ALIAS_BASE), .ALIAS_EN(ALIAS_EN)
   ) i_decode (
      .addr_i(bus_addr_i), .hit_o(hit), .wr_ok_o(wr_ok), .word_o(word)
   );

   assign we_acc = bus_we_i && wr_ok && !man_rst_i;

   ccreg_file #(
      .ASID_W(ASID_W), .BRK_W(BRK_W), .QMAP_N(2),
      .VERSION_ID(VERSION_ID), .PROD_ID(PROD_ID), .MANUAL_EXC(MANUAL_EXC)
   ) i_file (
      .clk_i(clk_i), .rst_ni(rst_ni), .man_rst_i(man_rst_i), .we_i(we_acc),
      .word_i(word), .wdata_i(bus_wdata_i), .rdata_o(rd_comb),
      .asid_o(asid), .xlat_en_o(xlat_en)
   );

   ccreg_cmd #(.ASID_W(ASID_W)) i_cmd (
      .clk_i(clk_i), .rst_ni(rst_ni), .man_rst_i(man_rst_i), .we_i(we_acc),
      .word_i(word), .wdata_i(bus_wdata_i), .asid_i(asid), .xlat_en_i(xlat_en),
      .pulse_o(pulse)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               rdata_q <= '0;
      else if (bus_re_i && hit)  rdata_q <= rd_comb;
      else                       rdata_q <= '0;
   end

   assign bus_rdata_o    = rdata_q;
   assign tlb_flush_o    = pulse.tlb_flush;
   assign lookup_flush_o = pulse.lookup_flush;
   assign icache_inv_o   = pulse.icache_inv;
   assign ocache_inv_o   = pulse.ocache_inv;
   assign xlat_mode_o    = pulse.xlat_mode;
   assign qremap_o       = pulse.qremap;

   // R1: no read strobe, no data
   a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_re_i |=> bus_rdata_o == '0);
   // R7: identification word is constant
   a_r7_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_re_i && hit && word == W_ID) |=> bus_rdata_o == VERSION_ID);
   // R9: break identifiers read zero-extended
   a_r9_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_re_i && hit && (word == W_BRK_A || word == W_BRK_B)) |=> bus_rdata_o[31:BRK_W] == '0);
   // R5: command bits of cache control read as zero
   a_r5_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_re_i && hit && word == W_CACHE_CTRL) |=>
         !bus_rdata_o[CC_IINV_BIT] && !bus_rdata_o[CC_OINV_BIT]);
   // R6: queue-map update pulse follows a queue-map write
   a_r6_qremap_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      qremap_o |-> $past(bus_we_i && hit && (word == W_QMAP0 || word == W_QMAP1)));

endmodule

// File: tb/test_ccreg_bank.sv
`timescale 1ns/1ps
module test_ccreg_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        man_rst = 1'b0;
   logic [31:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic        re = 1'b0;
   logic [31:0] rdata;
   logic        tlb_f, lk_f, ic_i, oc_i, xm, qr;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] mdl [0:17];

   always #10 clk = ~clk;

   ccreg_bank i_ccreg_bank (
      .clk_i(clk), .rst_ni(rst_n), .man_rst_i(man_rst),
      .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_re_i(re),
      .bus_rdata_o(rdata), .tlb_flush_o(tlb_f), .lookup_flush_o(lk_f),
      .icache_inv_o(ic_i), .ocache_inv_o(oc_i), .xlat_mode_o(xm), .qremap_o(qr)
   );

   function automatic logic [31:0] wmask(int w);
      case (w)
         0: return 32'hFFFF_FCFF;
         4: return 32'hFCFC_FF01;
         5, 6: return 32'h0000_00FF;
         7: return 32'h0000_81A7;
         14, 15: return 32'h0000_001C;
         1, 2, 3, 8, 9, 10, 13: return 32'hFFFF_FFFF;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] rexp(int w);
      case (w)
         12: return 32'h0402_05C1;
         11, 16, 17: return 32'h0;
         default: return mdl[w];
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mkaddr(int w, int sel);
      logic [31:0] base;
      base = (sel == 0) ? 32'h7F00_0000 : (sel == 1) ? 32'hFF00_0000 : 32'h1F00_0000;
      return base | (32'(w) << 2) | 32'($urandom_range(0, 3));
   endfunction

   // sel: 0 outside window, 1 primary, 2 alias
   task automatic do_write(int w, int sel, logic [31:0] d);
      logic [4:0] exp_p;
      logic       exp_x;
      string      tag;
      exp_p = '0; exp_x = 1'b0; tag = "R11 no pulse";
      if (sel != 0) begin
         case (w)
            0: begin exp_p[3] = (d[7:0] != mdl[0][7:0]); tag = "R2 lookup"; end
            4: begin exp_p[4] = d[2]; exp_x = (d[0] != mdl[4][0]); tag = "R3 flush"; end
            7: begin exp_p[2] = d[11]; exp_p[1] = d[3]; tag = "R5 invalidate"; end
            14, 15: begin exp_p[0] = 1'b1; tag = "R6 qremap"; end
            default: ;
         endcase
      end
      @(negedge clk);
      addr = mkaddr(w, sel); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      if (sel != 0) mdl[w] = (d & wmask(w)) | (mdl[w] & ~wmask(w));
      check(tag, {27'd0, tlb_f, lk_f, ic_i, oc_i, qr}, {27'd0, exp_p});
      check("R4 mode pulse", {31'd0, xm}, {31'd0, exp_x});
   endtask

   task automatic do_read(int w, int sel, string tag);
      @(negedge clk);
      addr = mkaddr(w, sel); re = 1'b1;
      @(negedge clk);
      re = 1'b0;
      check(tag, rdata, (sel == 0) ? 32'h0 : rexp(w));
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 18; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state, R7 constants
      for (int w = 0; w < 18; w++) do_read(w, 1, (w == 12 || w == 17) ? "R7 id" : "R8 reset");
      check("R1 idle read", rdata, 32'h0);

      // directed corners
      do_write(0, 1, 32'h0000_0355);            // R2 change, bits 9:8 masked
      do_read(0, 2, "R2 mask");
      do_write(0, 1, 32'hABCD_0055);            // R2 same identifier: no pulse
      do_write(4, 1, 32'hFFFF_FFFF);            // R3 + R4 set enable
      do_read(4, 1, "R3 flush reads 0");
      do_write(4, 2, 32'h0000_0001);            // R4 no change
      do_write(4, 1, 32'h0000_0004);            // R4 clear enable, R3 flush
      do_write(7, 1, 32'hFFFF_FFFF);            // R5 both invalidates
      do_read(7, 1, "R5 mask");
      do_write(14, 1, 32'hFFFF_FFFF);           // R6
      do_write(15, 2, 32'h0000_0000);
      do_read(14, 2, "R6 mask");
      do_write(5, 1, 32'h1234_56A5);
      do_read(5, 1, "R9 zero ext");
      do_write(12, 1, 32'hDEAD_BEEF);           // R7 ignored
      do_read(12, 1, "R7 id held");
      do_write(17, 2, 32'hDEAD_BEEF);
      do_read(17, 2, "R7 prod held");
      do_write(11, 1, 32'hFFFF_FFFF);           // R1 unmapped
      do_read(11, 1, "R1 unmapped");
      do_write(2, 0, 32'hFFFF_FFFF);            // R1 outside window
      do_read(2, 1, "R1 outside ignored");
      do_write(8, 1, 32'hCAFE_F00D);
      do_read(8, 2, "R10 plain");

      // R1 read during write returns old value
      @(negedge clk);
      addr = 32'hFF00_0004; wdata = 32'h5A5A_5A5A; we = 1'b1; re = 1'b1;
      @(negedge clk);
      we = 1'b0; re = 1'b0;
      check("R1 read before write", rdata, mdl[1]);
      mdl[1] = 32'h5A5A_5A5A;
      do_read(1, 1, "R10 plain after");

      // R8 manual reset
      do_write(4, 1, 32'h0000_0101);
      do_write(7, 1, 32'h0000_0021);
      do_write(9, 1, 32'h0000_0777);
      @(negedge clk);
      man_rst = 1'b1; addr = 32'hFF00_001C; wdata = 32'hFFFF_FFFF; we = 1'b1;
      @(negedge clk);
      man_rst = 1'b0; we = 1'b0;
      check("R8 manual no pulse", {26'd0, tlb_f, lk_f, ic_i, oc_i, xm, qr}, 32'h0);
      mdl[4] = 0; mdl[7] = 0; mdl[9] = 32'h20;
      for (int w = 0; w < 18; w++) do_read(w, 1, "R8 manual");

      // random traffic
      for (int k = 0; k < 1500; k++) begin
         int w, s, r;
         w = $urandom_range(0, 17);
         r = $urandom_range(0, 9);
         s = (r == 0) ? 0 : (r < 6) ? 1 : 2;
         if ($urandom_range(0, 9) < 6) begin
            logic [31:0] d;
            d = $urandom();
            if ($urandom_range(0, 3) == 0) d[7:0] = mdl[0][7:0];
            do_write(w, s, d);
         end else begin
            do_read(w, s, "R10 random read");
         end
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule